// File: doc/BRIEF.md
# Gate Driver Fault Response Controller

This block decides how a three-phase gate driver reacts to each protection event. It receives comparator flags that are already synchronized to its clock. The flags cover three supply undervoltage monitors, charge-pump undervoltage, overvoltage, overcurrent, per-side current limit, thermal warning, thermal shutdown, serial-interface framing errors and configuration-memory read errors. From these flags the block drives four things: an active-low fault pin, a bridge high-impedance request, per-side current-limit blanking for each phase, and a logic enable. It also keeps a status vector of sticky and live fault bits.

Each fault class has its own reaction. Some latch until they are cleared, some retry after a programmed number of cycles, some only report, and some follow the live condition. Several classes have a mode input that selects the reaction. A current-limit event blanks only the side that tripped. That side is released on the next rising edge of its own PWM input. A clear strobe releases a sticky bit only when the condition behind it has gone away. A sleep reset pulse does the same for every sticky bit except the memory-error latch.

The block has no data stream, so every pin is a plain level or a single-cycle strobe and no valid/ready handshake is used. All flag, mode and strobe inputs are sampled on the rising clock edge. Every output comes straight from registers.

Top module: `fault_resp_ctrl`

## Requirements
- R1: All outputs reflect inputs sampled at the previous rising edge. The status vector uses this bit layout: 0 supply UV, 1 charge-pump UV, 2 overvoltage, 3 overcurrent, 4 current limit, 5 serial error, 6 memory error, 7 thermal warning, 8 thermal shutdown. `fault_n_o` is low exactly when any of status bits 1 to 8 is set.
- R2: Any supply UV flag drives `hiz_o` high and `logic_en_o` low one cycle later. Both recover automatically when every UV flag is low. Status bit 0 is sticky: it stays set until a clear or sleep pulse arrives with no UV flag present. Bit 0 never drives the fault pin.
- R3: Charge-pump UV, thermal shutdown, and overvoltage with `ov_en_i`=1 each set their status bit and `hiz_o` for as long as their flag is high. Overvoltage with `ov_en_i`=0 has no effect.
- R4: With `oc_mode_i`=00, overcurrent latches `hiz_o` and status bit 3. Both are released only by a clear or sleep pulse taken while the overcurrent flag is low.
- R5: With `oc_mode_i`=01, overcurrent holds `hiz_o` for max(`retry_len_i`,1) cycles counted from entry. If the flag is still high when the count expires, the count restarts.
- R6: With `oc_mode_i`=10, overcurrent sets status bit 3 and leaves `hiz_o` low. With `oc_mode_i`=11, overcurrent changes no output.
- R7: A current-limit flag for one side of a phase sets that side's limit output on the next cycle. The output clears one cycle after a rising edge of that side's PWM input, provided the flag is low at that edge.
- R8: With `ilim_rpt_i`=1, any current-limit flag sets sticky status bit 4. With `ilim_rpt_i`=0, status bit 4 is not set.
- R9: With `spi_rpt_i`=1, a serial error sets sticky status bit 5. With `spi_rpt_i`=0, a serial error has no effect.
- R10: A memory read error latches status bit 6 and `hiz_o`. A sleep pulse does not release it. A clear pulse releases it when the flag is low, and so does reset.
- R11: With `tw_rpt_i`=1, status bit 7 follows the thermal warning flag and never drives `hiz_o`. With `tw_rpt_i`=0, the warning is ignored.
- R12: A clear or sleep pulse taken while a sticky bit's condition is still present leaves that bit set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset (power cycle) |
| uv_i | input | 3 | Supply undervoltage flags |
| cp_uv_i | input | 1 | Charge-pump undervoltage flag |
| ov_i | input | 1 | Overvoltage flag |
| oc_i | input | 1 | Overcurrent flag |
| ilim_hs_i | input | NPH | High-side current-limit flags, one per phase |
| ilim_ls_i | input | NPH | Low-side current-limit flags, one per phase |
| tw_i | input | 1 | Thermal warning flag |
| tsd_i | input | 1 | Thermal shutdown flag |
| spi_err_i | input | 1 | Serial framing, parity or address error flag |
| otp_err_i | input | 1 | Configuration-memory read error flag |
| oc_mode_i | input | 2 | Overcurrent reaction: 00 latch, 01 retry, 10 report, 11 ignore |
| ov_en_i | input | 1 | Enable overvoltage protection |
| ilim_rpt_i | input | 1 | Report current limit on the fault pin |
| spi_rpt_i | input | 1 | Report serial errors |
| tw_rpt_i | input | 1 | Report thermal warning |
| retry_len_i | input | RETRY_W | Overcurrent retry length in cycles |
| clr_flt_i | input | 1 | Single-cycle clear-fault strobe |
| sleep_pulse_i | input | 1 | Single-cycle sleep reset pulse |
| pwm_hs_i | input | NPH | High-side PWM inputs |
| pwm_ls_i | input | NPH | Low-side PWM inputs |
| fault_n_o | output | 1 | Active-low fault pin |
| hiz_o | output | 1 | Bridge high-impedance request |
| logic_en_o | output | 1 | Logic enable (low during supply UV) |
| hs_lim_o | output | NPH | High side held off by current limit |
| ls_lim_o | output | NPH | Low side held off by current limit |
| status_o | output | 9 | Fault status vector (layout in R1) |

## Verification
Every output is registered. Each result is therefore due in the first cycle after the rising edge that samples the stimulus. There are two exceptions. The retry window of R5 lasts the programmed number of cycles from that edge. A limit release in R7 appears one cycle after the sampled PWM rise. The bench changes its inputs just after a falling edge and updates its reference model at the rising edge. It compares every output at the next falling edge, so each check lands half a cycle after the result is due. The directed checks count falling edges from the stimulus edge, for example to measure how long `hiz_o` stays high during a retry.

// File: rtl/fault_resp_pkg.sv
package fault_resp_pkg;

  // status vector layout
  localparam int ST_UV   = 0;
  localparam int ST_CP   = 1;
  localparam int ST_OV   = 2;
  localparam int ST_OC   = 3;
  localparam int ST_ILIM = 4;
  localparam int ST_SPI  = 5;
  localparam int ST_OTP  = 6;
  localparam int ST_TW   = 7;
  localparam int ST_TSD  = 8;
  localparam int ST_W    = 9;

  typedef enum logic [1:0] {
    OC_LATCH  = 2'b00,
    OC_RETRY  = 2'b01,
    OC_REPORT = 2'b10,
    OC_OFF    = 2'b11
  } oc_mode_e;

endpackage

// File: rtl/fr_sticky.sv
module fr_sticky (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic cond_i,
  input  logic clr_i,
  output logic q_o
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               q_o <= 1'b0;
    else if (set_i)           q_o <= 1'b1;
    else if (clr_i && !cond_i) q_o <= 1'b0;
  end

  AST_STICKY_SET: assert property (@(posedge clk) disable iff (!rst_n)
    set_i |=> q_o); // R12

  AST_STICKY_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (q_o && (!clr_i || cond_i)) |=> q_o); // R12

endmodule

// File: rtl/fr_retry_timer.sv
module fr_retry_timer #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [CNT_W-1:0] len_i,
  output logic             expire_o
);

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cnt <= '0;
    else if (load_i)        cnt <= (len_i == '0) ? ONE : len_i;
    else if (cnt != '0)     cnt <= cnt - ONE;
  end

  assign expire_o = (cnt == ONE);

  AST_RETRY_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_i && cnt > ONE) |=> (cnt == $past(cnt) - ONE)); // R5

  AST_RETRY_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> (cnt != '0)); // R5

endmodule

// File: rtl/fr_ilim_side.sv
module fr_ilim_side (
  input  logic clk,
  input  logic rst_n,
  input  logic lim_i,
  input  logic pwm_i,
  output logic blk_o
);

  logic pwm_q;
  logic pwm_rise;

  assign pwm_rise = pwm_i & ~pwm_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pwm_q <= 1'b0;
      blk_o <= 1'b0;
    end else begin
      pwm_q <= pwm_i;
      if (lim_i)         blk_o <= 1'b1;
      else if (pwm_rise) blk_o <= 1'b0;
    end
  end

  AST_ILIM_ENTER: assert property (@(posedge clk) disable iff (!rst_n)
    lim_i |=> blk_o); // R7

  AST_ILIM_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
    (blk_o && !pwm_i) |=> blk_o); // R7

  AST_ILIM_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    (!lim_i && pwm_i && !pwm_q) |=> !blk_o); // R7

endmodule

// File: rtl/fault_resp_ctrl.sv
module fault_resp_ctrl
  import fault_resp_pkg::*;
#(
  parameter int NPH     = 3,
  parameter int RETRY_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [2:0]         uv_i,
  input  logic               cp_uv_i,
  input  logic               ov_i,
  input  logic               oc_i,
  input  logic [NPH-1:0]     ilim_hs_i,
  input  logic [NPH-1:0]     ilim_ls_i,
  input  logic               tw_i,
  input  logic               tsd_i,
  input  logic               spi_err_i,
  input  logic               otp_err_i,
  input  logic [1:0]         oc_mode_i,
  input  logic               ov_en_i,
  input  logic               ilim_rpt_i,
  input  logic               spi_rpt_i,
  input  logic               tw_rpt_i,
  input  logic [RETRY_W-1:0] retry_len_i,
  input  logic               clr_flt_i,
  input  logic               sleep_pulse_i,
  input  logic [NPH-1:0]     pwm_hs_i,
  input  logic [NPH-1:0]     pwm_ls_i,
  output logic               fault_n_o,
  output logic               hiz_o,
  output logic               logic_en_o,
  output logic [NPH-1:0]     hs_lim_o,
  output logic [NPH-1:0]     ls_lim_o,
  output logic [ST_W-1:0]    status_o
);

  // sticky slots
  localparam int K_UV   = 0;
  localparam int K_OC   = 1;
  localparam int K_IL   = 2;
  localparam int K_SPI  = 3;
  localparam int K_OTP  = 4;
  localparam int NSTK   = 5;

  oc_mode_e oc_mode;
  logic     clr_any;
  logic     uv_any;
  logic     ilim_any;

  assign oc_mode  = oc_mode_e'(oc_mode_i);
  assign clr_any  = clr_flt_i | sleep_pulse_i;
  assign uv_any   = |uv_i;
  assign ilim_any = (|ilim_hs_i) | (|ilim_ls_i);

  // ---------------- sticky status bits ----------------
  logic [NSTK-1:0] stk_set, stk_cond, stk_clr, stk_q;

  always_comb begin
    stk_set[K_UV]   = uv_any;
    stk_cond[K_UV]  = uv_any;
    stk_clr[K_UV]   = clr_any;

    stk_set[K_OC]   = oc_i && (oc_mode != OC_OFF);
    stk_cond[K_OC]  = oc_i;
    stk_clr[K_OC]   = clr_any;

    stk_set[K_IL]   = ilim_any && ilim_rpt_i;
    stk_cond[K_IL]  = ilim_any;
    stk_clr[K_IL]   = clr_any;

    stk_set[K_SPI]  = spi_err_i && spi_rpt_i;
    stk_cond[K_SPI] = spi_err_i;
    stk_clr[K_SPI]  = clr_any;

    // memory error: only the clear strobe releases it
    stk_set[K_OTP]  = otp_err_i;
    stk_cond[K_OTP] = otp_err_i;
    stk_clr[K_OTP]  = clr_flt_i;
  end

  for (genvar g = 0; g < NSTK; g++) begin : g_stk
    fr_sticky u_stk (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_i  (stk_set[g]),
      .cond_i (stk_cond[g]),
      .clr_i  (stk_clr[g]),
      .q_o    (stk_q[g])
    );
  end

  // ---------------- live-following classes ----------------
  logic uv_q, cp_q, ov_q, tw_q, tsd_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      uv_q  <= 1'b0;
      cp_q  <= 1'b0;
      ov_q  <= 1'b0;
      tw_q  <= 1'b0;
      tsd_q <= 1'b0;
    end else begin
      uv_q  <= uv_any;
      cp_q  <= cp_uv_i;
      ov_q  <= ov_i & ov_en_i;
      tw_q  <= tw_i & tw_rpt_i;
      tsd_q <= tsd_i;
    end
  end

  // ---------------- overcurrent bridge hold ----------------
  logic oc_hiz;
  logic rt_load;
  logic rt_exp;

  assign rt_load = (oc_mode == OC_RETRY) && oc_i && (!oc_hiz || rt_exp);

  fr_retry_timer #(.CNT_W(RETRY_W)) u_retry (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_i   (rt_load),
    .len_i    (retry_len_i),
    .expire_o (rt_exp)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                        oc_hiz <= 1'b0;
    else if (oc_mode_i[1])                             oc_hiz <= 1'b0;
    else if (clr_any && !oc_i)                         oc_hiz <= 1'b0;
    else if (oc_mode == OC_RETRY && rt_exp && !oc_i)   oc_hiz <= 1'b0;
    else if (oc_i)                                     oc_hiz <= 1'b1;
  end

  // ---------------- current-limit blanking ----------------
  for (genvar p = 0; p < NPH; p++) begin : g_ph
    fr_ilim_side u_hs (
      .clk   (clk),
      .rst_n (rst_n),
      .lim_i (ilim_hs_i[p]),
      .pwm_i (pwm_hs_i[p]),
      .blk_o (hs_lim_o[p])
    );
    fr_ilim_side u_ls (
      .clk   (clk),
      .rst_n (rst_n),
      .lim_i (ilim_ls_i[p]),
      .pwm_i (pwm_ls_i[p]),
      .blk_o (ls_lim_o[p])
    );
  end

  // ---------------- outputs ----------------
  always_comb begin
    status_o          = '0;
    status_o[ST_UV]   = stk_q[K_UV];
    status_o[ST_CP]   = cp_q;
    status_o[ST_OV]   = ov_q;
    status_o[ST_OC]   = stk_q[K_OC];
    status_o[ST_ILIM] = stk_q[K_IL];
    status_o[ST_SPI]  = stk_q[K_SPI];
    status_o[ST_OTP]  = stk_q[K_OTP];
    status_o[ST_TW]   = tw_q;
    status_o[ST_TSD]  = tsd_q;
  end

  assign fault_n_o  = ~(|status_o[ST_W-1:ST_CP]);
  assign hiz_o      = uv_q | cp_q | ov_q | oc_hiz | stk_q[K_OTP] | tsd_q;
  assign logic_en_o = ~uv_q;

  AST_UV_SAFE: assert property (@(posedge clk) disable iff (!rst_n)
    (|uv_i) |=> (hiz_o && !logic_en_o)); // R2

  AST_TSD_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    tsd_i |=> (hiz_o && !fault_n_o)); // R3

  AST_OC_LATCHED: assert property (@(posedge clk) disable iff (!rst_n)
    (oc_mode == OC_LATCH && oc_hiz && !clr_any) |=> hiz_o); // R4

  AST_OTP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (status_o[ST_OTP] && !clr_flt_i) |=> (status_o[ST_OTP] && hiz_o)); // R10

  AST_OC_REPORT_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (oc_mode_i[1] && !uv_any && !cp_uv_i && !(ov_i && ov_en_i) && !tsd_i
     && !otp_err_i && !status_o[ST_OTP]) |=> !hiz_o); // R6

endmodule

// File: tb/fault_resp_ctrl_tb.sv
`timescale 1ns/1ps
module fault_resp_ctrl_tb;
  import fault_resp_pkg::*;

  localparam int NPH = 3;
  localparam int RW  = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [2:0] uv_i = '0;
  logic cp_uv_i = 0, ov_i = 0, oc_i = 0, tw_i = 0, tsd_i = 0, spi_err_i = 0, otp_err_i = 0;
  logic [NPH-1:0] ilim_hs_i = '0, ilim_ls_i = '0, pwm_hs_i = '0, pwm_ls_i = '0;
  logic [1:0] oc_mode_i = 2'b00;
  logic ov_en_i = 0, ilim_rpt_i = 0, spi_rpt_i = 0, tw_rpt_i = 0;
  logic [RW-1:0] retry_len_i = RW'(4);
  logic clr_flt_i = 0, sleep_pulse_i = 0;

  logic fault_n_o, hiz_o, logic_en_o;
  logic [NPH-1:0] hs_lim_o, ls_lim_o;
  logic [ST_W-1:0] status_o;

  always #2.5 clk = ~clk;

  fault_resp_ctrl #(.NPH(NPH), .RETRY_W(RW)) u_dut (
    .clk(clk), .rst_n(rst_n), .uv_i(uv_i), .cp_uv_i(cp_uv_i), .ov_i(ov_i), .oc_i(oc_i),
    .ilim_hs_i(ilim_hs_i), .ilim_ls_i(ilim_ls_i), .tw_i(tw_i), .tsd_i(tsd_i),
    .spi_err_i(spi_err_i), .otp_err_i(otp_err_i), .oc_mode_i(oc_mode_i), .ov_en_i(ov_en_i),
    .ilim_rpt_i(ilim_rpt_i), .spi_rpt_i(spi_rpt_i), .tw_rpt_i(tw_rpt_i),
    .retry_len_i(retry_len_i), .clr_flt_i(clr_flt_i), .sleep_pulse_i(sleep_pulse_i),
    .pwm_hs_i(pwm_hs_i), .pwm_ls_i(pwm_ls_i), .fault_n_o(fault_n_o), .hiz_o(hiz_o),
    .logic_en_o(logic_en_o), .hs_lim_o(hs_lim_o), .ls_lim_o(ls_lim_o), .status_o(status_o)
  );

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  bit m_uv, m_cp, m_ov, m_tw, m_tsd;           // live-following state
  bit s_uv, s_oc, s_il, s_spi, s_otp;          // sticky state
  bit m_ochold;
  int m_left;                                  // retry cycles remaining
  bit m_hs[NPH], m_ls[NPH], m_phs[NPH], m_pls[NPH];

  always @(posedge clk) begin
    if (!rst_n) begin
      m_uv = 0; m_cp = 0; m_ov = 0; m_tw = 0; m_tsd = 0;
      s_uv = 0; s_oc = 0; s_il = 0; s_spi = 0; s_otp = 0;
      m_ochold = 0; m_left = 0;
      for (int p = 0; p < NPH; p++) begin m_hs[p] = 0; m_ls[p] = 0; m_phs[p] = 0; m_pls[p] = 0; end
    end else begin
      bit any_clr, any_uv, any_il, ends_now, reload;
      any_clr = clr_flt_i || sleep_pulse_i;
      any_uv  = (uv_i != 0);
      any_il  = (ilim_hs_i != 0) || (ilim_ls_i != 0);
      ends_now = (m_left == 1);
      reload   = (oc_mode_i == 2'b01) && oc_i && (!m_ochold || ends_now);
      // overcurrent bridge hold
      if (oc_mode_i >= 2) m_ochold = 0;
      else if (any_clr && !oc_i) m_ochold = 0;
      else if (oc_mode_i == 2'b01 && ends_now && !oc_i) m_ochold = 0;
      else if (oc_i) m_ochold = 1;
      if (reload) m_left = (retry_len_i == 0) ? 1 : int'(retry_len_i);
      else if (m_left > 0) m_left--;
      // sticky bits
      s_uv  = any_uv || (s_uv && !any_clr);
      if (oc_i && oc_mode_i != 2'b11) s_oc = 1; else if (any_clr && !oc_i) s_oc = 0;
      if (any_il && ilim_rpt_i) s_il = 1; else if (any_clr && !any_il) s_il = 0;
      if (spi_err_i && spi_rpt_i) s_spi = 1; else if (any_clr && !spi_err_i) s_spi = 0;
      if (otp_err_i) s_otp = 1; else if (clr_flt_i) s_otp = 0;
      // live bits
      m_uv = any_uv; m_cp = cp_uv_i; m_ov = ov_i && ov_en_i;
      m_tw = tw_i && tw_rpt_i; m_tsd = tsd_i;
      // current-limit sides
      for (int p = 0; p < NPH; p++) begin
        if (ilim_hs_i[p]) m_hs[p] = 1; else if (pwm_hs_i[p] && !m_phs[p]) m_hs[p] = 0;
        if (ilim_ls_i[p]) m_ls[p] = 1; else if (pwm_ls_i[p] && !m_pls[p]) m_ls[p] = 0;
        m_phs[p] = pwm_hs_i[p];
        m_pls[p] = pwm_ls_i[p];
      end
    end
  end

  function automatic string bit_req(input int b);
    case (b)
      ST_UV:   return "R2 status uv";
      ST_CP:   return "R3 status cp";
      ST_OV:   return "R3 status ov";
      ST_OC:   return "R4 status oc";
      ST_ILIM: return "R8 status ilim";
      ST_SPI:  return "R9 status spi";
      ST_OTP:  return "R10 status otp";
      ST_TW:   return "R11 status tw";
      default: return "R3 status tsd";
    endcase
  endfunction

  always @(negedge clk) begin
    if (rst_n && !done) begin
      bit [ST_W-1:0] e_st;
      bit e_hiz;
      e_st = '0;
      e_st[ST_UV] = s_uv;  e_st[ST_CP] = m_cp;  e_st[ST_OV] = m_ov;
      e_st[ST_OC] = s_oc;  e_st[ST_ILIM] = s_il; e_st[ST_SPI] = s_spi;
      e_st[ST_OTP] = s_otp; e_st[ST_TW] = m_tw; e_st[ST_TSD] = m_tsd;
      e_hiz = m_uv || m_cp || m_ov || m_ochold || s_otp || m_tsd;
      for (int b = 0; b < ST_W; b++)
        chk(status_o[b] == e_st[b], bit_req(b), int'(status_o[b]), int'(e_st[b]));
      chk(fault_n_o == !(|e_st[ST_W-1:1]), "R1 fault pin", int'(fault_n_o), int'(!(|e_st[ST_W-1:1])));
      chk(hiz_o == e_hiz, "R3 hiz (R4 R5 R10)", int'(hiz_o), int'(e_hiz));
      chk(logic_en_o == !m_uv, "R2 logic enable", int'(logic_en_o), int'(!m_uv));
      for (int p = 0; p < NPH; p++) begin
        chk(hs_lim_o[p] == m_hs[p], "R7 high-side limit", int'(hs_lim_o[p]), int'(m_hs[p]));
        chk(ls_lim_o[p] == m_ls[p], "R7 low-side limit", int'(ls_lim_o[p]), int'(m_ls[p]));
      end
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic clear_all();
    clr_flt_i = 1; cyc(1); clr_flt_i = 0; cyc(1);
  endtask

  // watchdog
  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int len;
    cyc(3);
    // reset state (R1)
    chk(fault_n_o == 1 && hiz_o == 0 && logic_en_o == 1 && status_o == 0,
        "R1 reset state", int'({fault_n_o, hiz_o, logic_en_o}), 3'b101);
    rst_n = 1;
    cyc(2);

    // R2 supply undervoltage
    uv_i = 3'b010; cyc(1);
    chk(hiz_o && !logic_en_o, "R2 uv entry", int'({hiz_o, logic_en_o}), 2'b10);
    chk(fault_n_o == 1, "R2 uv not on pin", int'(fault_n_o), 1);
    cyc(2); uv_i = 0; cyc(1);
    chk(!hiz_o && logic_en_o && status_o[ST_UV], "R2 auto recover, bit sticky",
        int'({hiz_o, logic_en_o, status_o[ST_UV]}), 3'b011);
    sleep_pulse_i = 1; cyc(1); sleep_pulse_i = 0;
    chk(status_o[ST_UV] == 0, "R2 sleep clears uv bit", int'(status_o[ST_UV]), 0);

    // R3 overvoltage enable
    ov_i = 1; cyc(1);
    chk(hiz_o == 0 && fault_n_o == 1, "R3 ov disabled ignored", int'({hiz_o, fault_n_o}), 2'b01);
    ov_en_i = 1; cyc(1);
    chk(hiz_o && status_o[ST_OV] && !fault_n_o, "R3 ov enabled", int'(hiz_o), 1);
    ov_i = 0; cyc(1);
    chk(!hiz_o && !status_o[ST_OV], "R3 ov recovers", int'(hiz_o), 0);

    // R4 latched overcurrent
    oc_mode_i = 2'b00; oc_i = 1; cyc(1); oc_i = 0; cyc(5);
    chk(hiz_o && status_o[ST_OC], "R4 latch holds", int'(hiz_o), 1);
    clear_all();
    chk(!hiz_o && !status_o[ST_OC], "R4 clear releases", int'(hiz_o), 0);

    // R5 retry length from entry
    oc_mode_i = 2'b01; retry_len_i = RW'(4);
    oc_i = 1; cyc(1); oc_i = 0;
    len = 0;
    while (hiz_o && len < 50) begin len++; cyc(1); end
    chk(len == 4, "R5 retry window", len, 4);
    // zero length counts as one
    retry_len_i = '0; oc_i = 1; cyc(1); oc_i = 0;
    len = 0;
    while (hiz_o && len < 50) begin len++; cyc(1); end
    chk(len == 1, "R5 minimum retry", len, 1);
    // restart while flag persists
    retry_len_i = RW'(3); oc_i = 1; cyc(7);
    chk(hiz_o == 1, "R5 retry restarts", int'(hiz_o), 1);
    oc_i = 0; cyc(4);
    clear_all();

    // R6 report-only and ignore
    oc_mode_i = 2'b10; oc_i = 1; cyc(1); oc_i = 0;
    chk(status_o[ST_OC] && !hiz_o && !fault_n_o, "R6 report only",
        int'({status_o[ST_OC], hiz_o}), 2'b10);
    clear_all();
    oc_mode_i = 2'b11; oc_i = 1; cyc(1); oc_i = 0;
    chk(!status_o[ST_OC] && !hiz_o && fault_n_o, "R6 ignore", int'(status_o[ST_OC]), 0);
    oc_mode_i = 2'b00;

    // R7 current limit side gating
    ilim_hs_i = 3'b010; cyc(1); ilim_hs_i = 0;
    chk(hs_lim_o == 3'b010 && ls_lim_o == 0 && !status_o[ST_ILIM], "R7 side blanked",
        int'(hs_lim_o), 2);
    cyc(3);
    chk(hs_lim_o == 3'b010, "R7 held until edge", int'(hs_lim_o), 2);
    pwm_hs_i = 3'b010; cyc(1);
    chk(hs_lim_o == 0, "R7 released on rise", int'(hs_lim_o), 0);
    pwm_hs_i = 0;

    // R8 current limit report
    ilim_rpt_i = 1; ilim_ls_i = 3'b001; cyc(1); ilim_ls_i = 0;
    chk(status_o[ST_ILIM] && !fault_n_o, "R8 ilim reported", int'(status_o[ST_ILIM]), 1);
    pwm_ls_i = 3'b001; cyc(1); pwm_ls_i = 0;
    clear_all();

    // R9 serial error, R12 clear while present
    spi_err_i = 1; cyc(1);
    chk(!status_o[ST_SPI] && fault_n_o, "R9 spi ignored", int'(status_o[ST_SPI]), 0);
    spi_rpt_i = 1; cyc(1);
    clr_flt_i = 1; cyc(1); clr_flt_i = 0; cyc(1);
    chk(status_o[ST_SPI] == 1, "R12 clear blocked while present", int'(status_o[ST_SPI]), 1);
    spi_err_i = 0; cyc(1);
    chk(status_o[ST_SPI] == 1, "R9 spi sticky", int'(status_o[ST_SPI]), 1);
    clear_all();
    chk(status_o[ST_SPI] == 0, "R9 spi cleared", int'(status_o[ST_SPI]), 0);

    // R10 memory error latch
    otp_err_i = 1; cyc(1); otp_err_i = 0;
    sleep_pulse_i = 1; cyc(1); sleep_pulse_i = 0; cyc(1);
    chk(status_o[ST_OTP] && hiz_o, "R10 sleep does not release", int'(status_o[ST_OTP]), 1);
    clear_all();
    chk(!status_o[ST_OTP] && !hiz_o, "R10 clear releases", int'(status_o[ST_OTP]), 0);

    // R11 thermal warning
    tw_i = 1; cyc(1);
    chk(!status_o[ST_TW], "R11 warning ignored", int'(status_o[ST_TW]), 0);
    tw_rpt_i = 1; cyc(1);
    chk(status_o[ST_TW] && !hiz_o && !fault_n_o, "R11 warning reported", int'(status_o[ST_TW]), 1);
    tw_i = 0; cyc(1);
    chk(!status_o[ST_TW] && fault_n_o, "R11 warning auto clear", int'(status_o[ST_TW]), 0);

    // R3 thermal shutdown and charge pump
    tsd_i = 1; cp_uv_i = 1; cyc(1);
    chk(hiz_o && status_o[ST_TSD] && status_o[ST_CP], "R3 tsd and cp", int'(hiz_o), 1);
    tsd_i = 0; cp_uv_i = 0; cyc(1);
    chk(!hiz_o && fault_n_o, "R3 tsd and cp recover", int'(hiz_o), 0);

    // random traffic against the model
    for (int i = 0; i < 4000; i++) begin
      uv_i      = ($urandom_range(0, 59) == 0) ? 3'($urandom_range(1, 7)) : 3'b000;
      cp_uv_i   = ($urandom_range(0, 19) == 0);
      ov_i      = ($urandom_range(0, 11) == 0);
      oc_i      = ($urandom_range(0, 7) == 0);
      tw_i      = ($urandom_range(0, 9) == 0);
      tsd_i     = ($urandom_range(0, 29) == 0);
      spi_err_i = ($urandom_range(0, 11) == 0);
      otp_err_i = ($urandom_range(0, 79) == 0);
      ilim_hs_i = ($urandom_range(0, 5) == 0) ? NPH'($urandom) : '0;
      ilim_ls_i = ($urandom_range(0, 5) == 0) ? NPH'($urandom) : '0;
      pwm_hs_i  = pwm_hs_i ^ NPH'($urandom_range(0, 7) & $urandom_range(0, 7));
      pwm_ls_i  = pwm_ls_i ^ NPH'($urandom_range(0, 7) & $urandom_range(0, 7));
      clr_flt_i     = ($urandom_range(0, 15) == 0);
      sleep_pulse_i = ($urandom_range(0, 23) == 0);
      if ($urandom_range(0, 99) == 0) oc_mode_i = 2'($urandom_range(0, 3));
      if ($urandom_range(0, 99) == 0) retry_len_i = RW'($urandom_range(0, 6));
      if ($urandom_range(0, 79) == 0) begin
        ov_en_i = 1'($urandom); ilim_rpt_i = 1'($urandom);
        spi_rpt_i = 1'($urandom); tw_rpt_i = 1'($urandom);
      end
      cyc(1);
    end
    cyc(2);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule